// File: doc/BRIEF.md
# Reed-Solomon Parity-Chain Encoder

This block turns a stream of 16-bit instruction words, delivered in program order with a valid strobe, into two 8-bit check words per instruction. These are meant to be stored in a parity memory next to the program. The first check word binds each instruction to the one after it. The second check word binds that first check word to the first check word of the instruction before. Changing or inserting one instruction therefore breaks the checks of its neighbours as well as its own. Both check words are systematic Reed-Solomon parities over GF(16), computed fully in parallel, so a new instruction is taken every clock.

A `start` pulse opens a program image and clears the chain. Instructions then follow with `in_valid`. The pair for instruction t can only be formed once instruction t+1 is known, so it comes out one cycle after that word is accepted, tagged with its index t. A `flush` pulse closes the image: the last instruction held is paired with an all-zero successor and sent out.

Top module: `rspc_parity_chain`

## Requirements
- R1: Arithmetic is in GF(16) with field polynomial x^4+x+1. An instruction is split into four 4-bit symbols, and bits 15:12 of the word named first in a message are the highest-degree coefficient.
- R2: out_p1 is the remainder of x^2·m(x) divided by g(x) = x^2 + 6x + 8, where m(x) is the 8-symbol message formed by instruction t followed by instruction t+1. The remainder's x^1 coefficient goes in bits 7:4 and its x^0 coefficient in bits 3:0.
- R3: out_p2 is the same kind of remainder over the 4-symbol message formed by out_p1 of instruction t followed by out_p1 of instruction t-1, using the same bit placement as R2.
- R4: When instruction t+1 is accepted (in_valid high, start and flush low) while instruction t is held, out_valid is high for exactly the next cycle, carrying that pair and out_idx = t. out_valid is low in every other cycle, including the reset state.
- R5: The first word after start produces no output. It becomes instruction 0, and its p1(t-1) is taken as zero.
- R6: A flush while a word is held emits that word's pair in the next cycle, computed with an all-zero next instruction. The chain then restarts: the next pair carries index 0 and uses zero as its previous p1. A flush with no word held emits nothing.
- R7: start overrides flush and drops any held word without emitting it. A word presented together with start becomes instruction 0. A word presented together with flush (and no start) is discarded.
- R8: out_p1, out_p2 and out_idx keep their values in every cycle where out_valid is low. They are zero after reset.
- R9: Cycles with in_valid, start and flush all low change nothing in the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new program image |
| flush | input | 1 | Closes the image and emits the last held instruction |
| in_valid | input | 1 | in_word carries the next instruction |
| in_word | input | INST_W (16) | Instruction word |
| out_valid | output | 1 | A parity pair is present |
| out_p1 | output | 8 | Check over this instruction and the next |
| out_p2 | output | 8 | Check over out_p1 and the previous out_p1 |
| out_idx | output | IDX_W (12) | Index of the instruction this pair belongs to |

## Verification
A long random instruction stream with random idle gaps tests the parallel encoders against long-division parities across the whole symbol range. The gaps show whether idle cycles disturb the chain. Directed images with a single word, an immediate flush, back-to-back starts and collisions of start, flush and valid separate the zero-successor and zero-predecessor rules from the ordinary case and confirm the priority among the control pulses. The hold rule is checked in every silent cycle. A checker additionally requires every emitted p2 to close a zero-syndrome codeword at both generator roots, which is independent of how the encoder works internally.

// File: rtl/rspc_pkg.sv
package rspc_pkg;

   localparam int SYM_W = 4;
   localparam int PAR_W = 2 * SYM_W;
   localparam logic [SYM_W-1:0] FIELD_LOW = 4'b0011;

   function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
      return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_LOW : '0);
   endfunction

   function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
      logic [SYM_W-1:0] acc;
      logic [SYM_W-1:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < SYM_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   // Horner evaluation of a 6-symbol codeword, highest degree in the top nibble
   function automatic logic [SYM_W-1:0] gf_eval6(input logic [6*SYM_W-1:0] cw,
                                                input logic [SYM_W-1:0] beta);
      logic [SYM_W-1:0] acc;
      acc = '0;
      for (int i = 5; i >= 0; i--) acc = gf_mul(acc, beta) ^ cw[i*SYM_W +: SYM_W];
      return acc;
   endfunction

endpackage

// File: rtl/rspc_gf_cmul.sv
module rspc_gf_cmul
   import rspc_pkg::*;
#(
   parameter logic [SYM_W-1:0] COEF = 4'h1
) (
   input  logic [SYM_W-1:0] a,
   output logic [SYM_W-1:0] y
);

   logic [SYM_W-1:0] part [SYM_W];

   for (genvar i = 0; i < SYM_W; i++) begin : g_bit
      localparam logic [SYM_W-1:0] CPOW = gf_mul(COEF, SYM_W'(1 << i));
      assign part[i] = a[i] ? CPOW : '0;
   end

   always_comb begin
      y = '0;
      for (int i = 0; i < SYM_W; i++) y = y ^ part[i];
   end

endmodule

// File: rtl/rspc_sys_enc.sv
module rspc_sys_enc
   import rspc_pkg::*;
#(
   parameter int               N_MSG = 8,
   parameter logic [SYM_W-1:0] G1    = 4'h6,
   parameter logic [SYM_W-1:0] G0    = 4'h8,
   localparam int              MSG_W = N_MSG * SYM_W
) (
   input  logic [MSG_W-1:0] msg,
   output logic [PAR_W-1:0] parity
);

   if (N_MSG < 1) begin : g_bad_len
      $error("rspc_sys_enc: N_MSG must be at least 1");
   end

   logic [N_MSG:0][SYM_W-1:0] r1_s;
   logic [N_MSG:0][SYM_W-1:0] r0_s;

   assign r1_s[0] = '0;
   assign r0_s[0] = '0;

   for (genvar k = 0; k < N_MSG; k++) begin : g_stage
      logic [SYM_W-1:0] fb;
      logic [SYM_W-1:0] fb_g1;
      logic [SYM_W-1:0] fb_g0;

      assign fb = msg[(N_MSG-1-k)*SYM_W +: SYM_W] ^ r1_s[k];

      rspc_gf_cmul #(.COEF(G1)) u_m1 (.a(fb), .y(fb_g1));
      rspc_gf_cmul #(.COEF(G0)) u_m0 (.a(fb), .y(fb_g0));

      assign r1_s[k+1] = r0_s[k] ^ fb_g1;
      assign r0_s[k+1] = fb_g0;
   end

   assign parity = {r1_s[N_MSG], r0_s[N_MSG]};

endmodule

// File: rtl/rspc_parity_chain.sv
module rspc_parity_chain
   import rspc_pkg::*;
#(
   parameter int               INST_W = 16,
   parameter int               IDX_W  = 12,
   parameter logic [SYM_W-1:0] G1     = 4'h6,
   parameter logic [SYM_W-1:0] G0     = 4'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [INST_W-1:0] in_word,
   output logic              out_valid,
   output logic [PAR_W-1:0]  out_p1,
   output logic [PAR_W-1:0]  out_p2,
   output logic [IDX_W-1:0]  out_idx
);

   localparam int INST_SYM = INST_W / SYM_W;
   localparam int P1_SYM   = 2 * INST_SYM;
   localparam int P2_SYM   = 2 * (PAR_W / SYM_W);

   if (INST_W % SYM_W != 0) begin : g_bad_width
      $error("rspc_parity_chain: INST_W must be a multiple of the symbol width");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("rspc_parity_chain: IDX_W must be at least 1");
   end

   logic              have_q;
   logic [INST_W-1:0] held_q;
   logic [PAR_W-1:0]  prev_q;
   logic [IDX_W-1:0]  idx_q;

   logic [INST_W-1:0] succ_word;
   logic              emit;
   logic [PAR_W-1:0]  p1_c;
   logic [PAR_W-1:0]  p2_c;

   assign succ_word = flush ? '0 : in_word;
   assign emit      = !start && have_q && (flush || in_valid);

   rspc_sys_enc #(.N_MSG(P1_SYM), .G1(G1), .G0(G0)) u_enc_p1 (
      .msg    ({held_q, succ_word}),
      .parity (p1_c)
   );

   rspc_sys_enc #(.N_MSG(P2_SYM), .G1(G1), .G0(G0)) u_enc_p2 (
      .msg    ({p1_c, prev_q}),
      .parity (p2_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q    <= 1'b0;
         held_q    <= '0;
         prev_q    <= '0;
         idx_q     <= '0;
         out_valid <= 1'b0;
         out_p1    <= '0;
         out_p2    <= '0;
         out_idx   <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_p1  <= p1_c;
            out_p2  <= p2_c;
            out_idx <= idx_q;
         end
         if (start) begin
            have_q <= in_valid;
            if (in_valid) held_q <= in_word;
            prev_q <= '0;
            idx_q  <= '0;
         end else if (flush) begin
            have_q <= 1'b0;
            prev_q <= '0;
            idx_q  <= '0;
         end else if (in_valid) begin
            have_q <= 1'b1;
            held_q <= in_word;
            if (have_q) begin
               prev_q <= p1_c;
               idx_q  <= idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rspc_parity_chain_chk.sv
module rspc_parity_chain_chk
   import rspc_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             flush,
   input logic             in_valid,
   input logic             out_valid,
   input logic [PAR_W-1:0] out_p1,
   input logic [PAR_W-1:0] out_p2,
   input logic [IDX_W-1:0] out_idx
);

   logic             flush_q;
   logic [IDX_W-1:0] next_idx;
   logic [PAR_W-1:0] chain_p1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q  <= 1'b0;
         next_idx <= '0;
         chain_p1 <= '0;
      end else begin
         flush_q <= flush && !start;
         if (start) begin
            next_idx <= '0;
            chain_p1 <= '0;
         end else if (flush_q) begin
            next_idx <= '0;
            chain_p1 <= '0;
         end else if (out_valid) begin
            next_idx <= out_idx + 1'b1;
            chain_p1 <= out_p1;
         end
      end
   end

   // R4: a pair appears only after an accepted word or a flush without start
   assert_emit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid || flush) && !$past(start)));

   // R7: start never produces a pair in the following cycle
   assert_start_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !out_valid);

   // R8: data outputs change only together with out_valid
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(out_p1) || !$stable(out_p2) || !$stable(out_idx)) |-> out_valid);

   // R5 / R6: indices count up from zero within one image
   assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_idx == next_idx));

   // R3: p1(t), p1(t-1), p2(t) form a codeword with zero syndromes at both roots
   assert_p2_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((gf_eval6({out_p1, chain_p1, out_p2}, 4'h2) == '0) &&
                     (gf_eval6({out_p1, chain_p1, out_p2}, 4'h4) == '0)));

endmodule

bind rspc_parity_chain rspc_parity_chain_chk #(.IDX_W(IDX_W)) u_rspc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .flush     (flush),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_p1    (out_p1),
   .out_p2    (out_p2),
   .out_idx   (out_idx)
);

// File: tb/test_rspc_parity_chain.sv
module test_rspc_parity_chain;

   localparam int CLK_PERIOD = 10;
   localparam int INST_W     = 16;
   localparam int IDX_W      = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              flush = 1'b0;
   logic              in_valid = 1'b0;
   logic [INST_W-1:0] in_word = '0;
   logic              out_valid;
   logic [7:0]        out_p1;
   logic [7:0]        out_p2;
   logic [IDX_W-1:0]  out_idx;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // model state
   bit               m_have = 0;
   logic [15:0]      m_held = '0;
   logic [7:0]       m_prev = '0;
   logic [IDX_W-1:0] m_idx = '0;
   bit               e_valid = 0;
   logic [7:0]       e_p1 = '0;
   logic [7:0]       e_p2 = '0;
   logic [IDX_W-1:0] e_idx = '0;

   rspc_parity_chain #(.INST_W(INST_W), .IDX_W(IDX_W)) i_rspc_parity_chain (
      .clk, .rst_n, .start, .flush, .in_valid, .in_word,
      .out_valid, .out_p1, .out_p2, .out_idx
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [3:0] fmul(input logic [3:0] a, input logic [3:0] b);
      logic [7:0] prod = '0;
      for (int i = 0; i < 4; i++) if (b[i]) prod = prod ^ (8'(a) << i);
      for (int i = 7; i >= 4; i--) if (prod[i]) prod = prod ^ (8'h13 << (i - 4));
      return prod[3:0];
   endfunction

   // long division of x^2*m(x) by x^2+6x+8; msg low nsym symbols, top symbol highest degree
   function automatic logic [7:0] rs_check(input logic [63:0] msg, input int nsym);
      logic [3:0] c [18];
      logic [3:0] q;
      for (int i = 0; i < 18; i++) c[i] = '0;
      for (int i = 0; i < nsym; i++) c[i+2] = msg[i*4 +: 4];
      for (int d = nsym + 1; d >= 2; d--) begin
         q = c[d];
         c[d] = '0;
         c[d-1] = c[d-1] ^ fmul(q, 4'h6);
         c[d-2] = c[d-2] ^ fmul(q, 4'h8);
      end
      return {c[1], c[0]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic make_pair(input logic [15:0] nxt);
      e_valid = 1;
      e_p1    = rs_check(64'({m_held, nxt}), 8);
      e_p2    = rs_check(64'({e_p1, m_prev}), 4);
      e_idx   = m_idx;
   endtask

   // one clock: drive at negedge, update model, check at the following negedge
   task automatic cyc(input bit s, input bit f, input bit v, input logic [15:0] w,
                      input string tag);
      start = s; flush = f; in_valid = v; in_word = w;
      e_valid = 0;
      if (s) begin
         m_have = v;
         if (v) m_held = w;
         m_prev = '0;
         m_idx  = '0;
      end else if (f) begin
         if (m_have) make_pair(16'h0000);
         m_have = 0;
         m_prev = '0;
         m_idx  = '0;
      end else if (v) begin
         if (m_have) begin
            make_pair(w);
            m_prev = e_p1;
            m_idx  = m_idx + 1'b1;
         end
         m_held = w;
         m_have = 1;
      end
      @(negedge clk);
      chk(out_valid == e_valid, tag, "out_valid", int'(out_valid), int'(e_valid));
      if (e_valid) begin
         chk(out_p1 == e_p1, "R1 R2", "out_p1", int'(out_p1), int'(e_p1));
         chk(out_p2 == e_p2, "R3", "out_p2", int'(out_p2), int'(e_p2));
         chk(out_idx == e_idx, "R4", "out_idx", int'(out_idx), int'(e_idx));
      end else begin
         chk(out_p1 == e_p1 && out_p2 == e_p2 && out_idx == e_idx, "R8",
             "held data p1/p2", int'({out_p1, out_p2}), int'({e_p1, e_p2}));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd1234;
      logic [15:0] rw;
      seed = $urandom(seed);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && out_p1 == '0 && out_p2 == '0 && out_idx == '0,
          "R4", "reset state", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: single word image, flush pairs with zero successor (R6)
      cyc(1, 0, 0, 16'h0000, "R5");
      cyc(0, 0, 1, 16'hA5C3, "R5");
      cyc(0, 1, 0, 16'h0000, "R6");
      cyc(0, 0, 0, 16'h0000, "R6");
      // R6: flush with nothing held emits nothing
      cyc(0, 1, 0, 16'h0000, "R6");
      // short image with idle gaps (R9)
      cyc(1, 0, 1, 16'h1234, "R7");
      cyc(0, 0, 0, 16'h0000, "R9");
      cyc(0, 0, 1, 16'hFFFF, "R4");
      cyc(0, 0, 0, 16'h0000, "R9");
      cyc(0, 0, 1, 16'h0000, "R4");
      cyc(0, 0, 1, 16'h8001, "R4");
      // R7: word together with flush is discarded
      cyc(0, 1, 1, 16'hDEAD, "R7");
      cyc(0, 0, 1, 16'h0F0F, "R6");
      cyc(0, 0, 1, 16'hF0F0, "R6");
      // R7: start drops held word, start wins over flush
      cyc(1, 1, 1, 16'h7777, "R7");
      cyc(0, 0, 1, 16'h3C3C, "R7");
      cyc(1, 0, 0, 16'h0000, "R7");
      cyc(0, 0, 1, 16'h0001, "R5");
      cyc(0, 0, 1, 16'h0002, "R5");

      // random stream
      cyc(1, 0, 0, 16'h0000, "R5");
      for (int n = 0; n < 1500; n++) begin
         int unsigned r = $urandom;
         rw = 16'($urandom);
         if (r % 97 == 0)      cyc(0, 1, 0, 16'h0000, "R6");
         else if (r % 89 == 0) cyc(1, 0, 1, rw, "R7");
         else if (r % 5 == 0)  cyc(0, 0, 0, rw, "R9");
         else                  cyc(0, 0, 1, rw, "R4");
      end
      cyc(0, 1, 0, 16'h0000, "R6");
      cyc(0, 0, 0, 16'h0000, "R9");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule